// File: doc/BRIEF.md
# Triggered Pattern Output Buffer

This block is a double-buffered output stage for two pattern groups that share one next-data byte. Software loads the next pattern over a small register bus. When a compare-match trigger pulse arrives, the buffered pattern moves into the output register that drives the pins. The pins can therefore change on a timer event and not when software happens to write.

A mode pin chooses one of two trigger schemes. In the shared scheme, one trigger moves both groups. In the separate scheme, each group has its own trigger. The mode also changes how the next-data byte appears on the bus. Each group has its own output enable.

There are two standby inputs. Hardware standby clears the storage. Software standby freezes it, so its contents survive until normal operation resumes.

The bus is a plain single-cycle register port with no back-pressure. A write takes effect on the clock edge where `wr_en` is high. `rdata` follows `addr` combinationally while `rd_en` is high and is 0x00 otherwise. The trigger pins are one-clock pulses sampled on the rising edge.

Top module: `pat_out_stage`

## Requirements
- R1: While `rst_n` is low, `pat_out` is 0x00. After reset is released, a read at offset 0xA4 returns 0x00.
- R2: With `split_mode`=0 (shared trigger), a write at offset 0xA4 loads all 8 next-data bits. A read at 0xA4 returns them, with bits 7:4 belonging to the upper group and bits 3:0 to the lower group.
- R3: With `split_mode`=0, a read at offset 0xA6 returns 0xFF, and a write at 0xA6 changes no next-data bit.
- R4: With `split_mode`=1, offset 0xA4 reaches bits 7:4 only and offset 0xA6 reaches bits 3:0 only. In each of these bytes the other four bits read as 1, and a write changes only the addressed nibble.
- R5: With `split_mode`=0, a pulse on `trig_lo` copies both nibbles to `pat_out` on the same edge, and `trig_hi` has no effect.
- R6: With `split_mode`=1, `trig_hi` copies only bits 7:4 and `trig_lo` copies only bits 3:0 to `pat_out`.
- R7: A group whose enable is low (`oe[1]` for bits 7:4, `oe[0]` for bits 3:0) keeps its `pat_out` bits when a trigger arrives.
- R8: When a trigger and a bus write fall on the same edge, `pat_out` takes the next-data value held before the write, and the write still lands.
- R9: While `hw_stby` is high, the next-data byte and `pat_out` are cleared to 0x00.
- R10: While `sw_stby` is high (and `hw_stby` low), the next-data byte and `pat_out` hold their values: bus writes and triggers are ignored. The held data reads back after `sw_stby` falls.
- R11: A read at any offset other than 0xA4 and 0xA6 returns 0x00, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| hw_stby | input | 1 | Hardware standby, clears storage |
| sw_stby | input | 1 | Software standby, freezes storage |
| split_mode | input | 1 | 0: one shared trigger, 1: one trigger per group |
| trig_hi | input | 1 | Compare-match pulse for the upper group |
| trig_lo | input | 1 | Compare-match pulse for the lower group (and for both when shared) |
| oe | input | 2 | Per-group output enable, bit 1 upper, bit 0 lower |
| addr | input | 8 | Register bus offset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| pat_out | output | 8 | Output data register driving the pins |

## Verification
The bench builds the block with its default parameters: 4-bit groups, the full byte at 0xA4 and the alternate byte at 0xA6. With these values the nibble boundary at bit 4 and both decoded offsets are exercised. This makes it possible to check that only one half of the byte is touched in the separate-trigger mode, and that the alternate offset turns into an all-ones byte in the shared mode. Collision of a trigger with a write, and both standby kinds, are driven against the same stored patterns so that loss or retention of data shows up at the pins.

// File: rtl/pob_pkg.sv
package pob_pkg;
  localparam int NGRP = 2;
  localparam int GRP_LO = 0;
  localparam int GRP_HI = 1;

  typedef enum logic {
    TRG_SHARED = 1'b0,
    TRG_SPLIT  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/pob_decode.sv
module pob_decode
  import pob_pkg::*;
#(
  parameter int GW = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_MAIN = 8'hA4,
  parameter logic [AW-1:0] OFS_ALT  = 8'hA6,
  localparam int DW = NGRP * GW
) (
  input  trig_mode_e       mode,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    nd_q,
  output logic [NGRP-1:0]  wr_grp,
  output logic [DW-1:0]    rdata
);
  logic hit_main, hit_alt;
  logic [DW-1:0] rd_mux;

  assign hit_main = (addr == OFS_MAIN);
  assign hit_alt  = (addr == OFS_ALT);

  always_comb begin
    wr_grp = '0;
    rd_mux = '0;
    if (mode == TRG_SHARED) begin
      if (hit_main) begin
        wr_grp = {NGRP{wr_en}};
        rd_mux = nd_q;
      end else if (hit_alt) begin
        rd_mux = '1;
      end
    end else begin
      if (hit_main) begin
        wr_grp[GRP_HI] = wr_en;
        rd_mux = {nd_q[DW-1 -: GW], {GW{1'b1}}};
      end else if (hit_alt) begin
        wr_grp[GRP_LO] = wr_en;
        rd_mux = {{GW{1'b1}}, nd_q[GW-1:0]};
      end
    end
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/pob_trig_route.sv
module pob_trig_route
  import pob_pkg::*;
(
  input  trig_mode_e      mode,
  input  logic            trig_hi,
  input  logic            trig_lo,
  input  logic [NGRP-1:0] oe,
  output logic [NGRP-1:0] fire
);
  logic [NGRP-1:0] pick;

  always_comb begin
    pick[GRP_LO] = trig_lo;
    pick[GRP_HI] = (mode == TRG_SPLIT) ? trig_hi : trig_lo;
  end

  assign fire = pick & oe;
endmodule

// File: rtl/pob_group.sv
module pob_group #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          wr,
  input  logic [GW-1:0] wd,
  input  logic          fire,
  output logic [GW-1:0] nd,
  output logic [GW-1:0] po
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd <= '0;
      po <= '0;
    end else if (clr) begin
      nd <= '0;
      po <= '0;
    end else if (!hold) begin
      if (wr)   nd <= wd;
      if (fire) po <= nd;
    end
  end
endmodule

// File: rtl/pat_out_stage.sv
module pat_out_stage
  import pob_pkg::*;
#(
  parameter int GW = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_MAIN = 8'hA4,
  parameter logic [AW-1:0] OFS_ALT  = 8'hA6,
  localparam int DW = NGRP * GW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            split_mode,
  input  logic            trig_hi,
  input  logic            trig_lo,
  input  logic [NGRP-1:0] oe,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   pat_out
);
  trig_mode_e      mode;
  logic [NGRP-1:0] wr_grp;
  logic [NGRP-1:0] fire;
  logic [DW-1:0]   nd_q;

  assign mode = trig_mode_e'(split_mode);

  pob_decode #(.GW(GW), .AW(AW), .OFS_MAIN(OFS_MAIN), .OFS_ALT(OFS_ALT)) u_dec (
    .mode   (mode),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .nd_q   (nd_q),
    .wr_grp (wr_grp),
    .rdata  (rdata)
  );

  pob_trig_route u_route (
    .mode    (mode),
    .trig_hi (trig_hi),
    .trig_lo (trig_lo),
    .oe      (oe),
    .fire    (fire)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pob_group #(.GW(GW)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hw_stby),
      .hold  (sw_stby),
      .wr    (wr_grp[g]),
      .wd    (wdata[g*GW +: GW]),
      .fire  (fire[g]),
      .nd    (nd_q[g*GW +: GW]),
      .po    (pat_out[g*GW +: GW])
    );
  end
endmodule

// File: rtl/pat_out_stage_chk.sv
module pat_out_stage_chk #(
  parameter int GW = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_ALT = 8'hA6,
  localparam int DW = 2 * GW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_stby,
  input logic          sw_stby,
  input logic          split_mode,
  input logic          trig_hi,
  input logic          trig_lo,
  input logic [1:0]    oe,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] nd_q,
  input logic [DW-1:0] pat_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pat_out == '0 && nd_q == '0));

  // R3
  alt_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !split_mode && addr == OFS_ALT) |-> rdata == {DW{1'b1}});

  // R5
  shared_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode && trig_lo && oe == 2'b11 && !sw_stby && !hw_stby)
      |=> pat_out == $past(nd_q));

  // R6
  split_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && !trig_lo && !hw_stby) |=> $stable(pat_out[GW-1:0]));

  // R7
  hi_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe[1] && !hw_stby) |=> $stable(pat_out[DW-1:GW]));

  // R9
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (nd_q == '0 && pat_out == '0));

  // R10
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(nd_q) && $stable(pat_out)));
endmodule

bind pat_out_stage pat_out_stage_chk #(.GW(GW), .AW(AW), .OFS_ALT(OFS_ALT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_stby    (hw_stby),
  .sw_stby    (sw_stby),
  .split_mode (split_mode),
  .trig_hi    (trig_hi),
  .trig_lo    (trig_lo),
  .oe         (oe),
  .addr       (addr),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .nd_q       (nd_q),
  .pat_out    (pat_out)
);

// File: tb/sim_pat_out_stage.sv
`timescale 1ns/1ps
module sim_pat_out_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0, sw_stby = 1'b0, split_mode = 1'b0;
  logic       trig_hi = 1'b0, trig_lo = 1'b0;
  logic [1:0] oe = 2'b11;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, pat_out;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  pat_out_stage u0 (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .split_mode(split_mode), .trig_hi(trig_hi), .trig_lo(trig_lo), .oe(oe),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .pat_out(pat_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic hi, input logic lo);
    @(negedge clk); trig_hi = hi; trig_lo = lo;
    @(negedge clk); trig_hi = 1'b0; trig_lo = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 pat_out in reset", pat_out, 8'h00);
    rst_n = 1'b1;
    bus_rd(8'hA4, rv); check("R1 next-data after reset", rv, 8'h00);
  endtask

  task automatic t_shared_rw;
    split_mode = 1'b0;
    bus_wr(8'hA4, 8'h5A);
    bus_rd(8'hA4, rv); check("R2 shared readback", rv, 8'h5A);
    bus_rd(8'hA6, rv); check("R3 alt reads ones", rv, 8'hFF);
    bus_wr(8'hA6, 8'h33);
    bus_rd(8'hA4, rv); check("R3 alt write ignored", rv, 8'h5A);
  endtask

  task automatic t_unmapped;
    bus_wr(8'h10, 8'h77);
    bus_rd(8'hA4, rv); check("R11 unmapped write ignored", rv, 8'h5A);
    bus_rd(8'h10, rv); check("R11 unmapped reads zero", rv, 8'h00);
  endtask

  task automatic t_shared_trig;
    oe = 2'b11;
    pulse(1'b1, 1'b0);
    check("R5 trig_hi ignored when shared", pat_out, 8'h00);
    pulse(1'b0, 1'b1);
    check("R5 shared copy both", pat_out, 8'h5A);
  endtask

  task automatic t_split;
    split_mode = 1'b1;
    bus_wr(8'hA4, 8'hC3);
    bus_rd(8'hA4, rv); check("R4 split upper view", rv, 8'hCF);
    bus_rd(8'hA6, rv); check("R4 lower kept", rv, 8'hFA);
    bus_wr(8'hA6, 8'h61);
    bus_rd(8'hA6, rv); check("R4 split lower view", rv, 8'hF1);
    bus_rd(8'hA4, rv); check("R4 upper kept", rv, 8'hCF);
    pulse(1'b1, 1'b0);
    check("R6 trig_hi upper only", pat_out, 8'hCA);
    pulse(1'b0, 1'b1);
    check("R6 trig_lo lower only", pat_out, 8'hC1);
  endtask

  task automatic t_oe;
    bus_wr(8'hA4, 8'h70);
    bus_wr(8'hA6, 8'h05);
    oe = 2'b01;
    pulse(1'b1, 1'b1);
    check("R7 disabled upper held", pat_out, 8'hC5);
    oe = 2'b11;
  endtask

  task automatic t_collide;
    split_mode = 1'b0;
    @(negedge clk); addr = 8'hA4; wdata = 8'h99; wr_en = 1'b1; trig_lo = 1'b1;
    @(negedge clk); wr_en = 1'b0; trig_lo = 1'b0;
    check("R8 old value copied", pat_out, 8'h75);
    bus_rd(8'hA4, rv); check("R8 write landed", rv, 8'h99);
    pulse(1'b0, 1'b1);
    check("R8 new value on next trigger", pat_out, 8'h99);
  endtask

  task automatic t_sw_stby;
    @(negedge clk); sw_stby = 1'b1;
    bus_wr(8'hA4, 8'h11);
    pulse(1'b0, 1'b1);
    check("R10 pins frozen", pat_out, 8'h99);
    @(negedge clk); sw_stby = 1'b0;
    bus_rd(8'hA4, rv); check("R10 data retained", rv, 8'h99);
  endtask

  task automatic t_hw_stby;
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    check("R9 pins cleared", pat_out, 8'h00);
    bus_rd(8'hA4, rv); check("R9 next-data cleared", rv, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_shared_rw();
        t_unmapped();
        t_shared_trig();
        t_split();
        t_oe();
        t_collide();
        t_sw_stby();
        t_hw_stby();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule